// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, once per fetch cycle, which hardware threads may dequeue a request from their fetch target queue and drive the instruction cache. A thread can be chosen only if it is not waiting on an instruction-cache miss, its queue holds at least one request, and it can deliver at least one instruction. Among those threads, the one with the fewest instructions in the decode, rename and dispatch stages wins. Equal counts are settled by a rotating pointer.

A mode input selects single-thread fetch or two-thread fetch. In single-thread mode one thread receives up to the whole fetch width. In two-thread mode a second thread fills whatever slots the first one leaves over. A width input selects a fetch width of 8 or 16 instructions. When the fetch buffer lacks room for a full fetch block, nothing is granted.

The grant and slot outputs are registered, so they appear one clock after the inputs are sampled.

Top module: `smt_fetch_pick`

## Requirements
- R1: Among eligible threads, the thread with the lowest occupancy count (`occ_i`, thread t in bits [t*7 +: 7]) is the primary grant.
- R2: A thread whose `miss_blk_i` bit is set is never granted.
- R3: A thread is never granted if its `q_nempty_i` bit is clear, or if its deliverable count (`avail_i`, thread t in bits [t*5 +: 5]) is zero.
- R4: Equal counts are resolved in increasing thread order, wrapping, starting at a pointer. The pointer is 0 after reset. After any grant it moves to one past the last granted thread: the second thread if one was granted, otherwise the primary.
- R5: With `two_thread_i` = 0, at most one thread is granted, and it receives min(avail, width) slots.
- R6: With `two_thread_i` = 1, the next-ranked eligible thread receives min(its avail, width − primary slots). It is granted only when that leftover is non-zero.
- R7: The fetch width is 16 when `wide_i` = 1 and 8 when `wide_i` = 0.
- R8: When `buf_free_i` is below the fetch width, no thread is granted, all slots are zero, and the pointer holds its value.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge. During reset all outputs are zero.
- R10: `alloc_o` (thread t in bits [t*5 +: 5]) is non-zero only for threads set in `grant_o`. `prim_o` is one-hot or zero and lies within `grant_o`. The total of the slots never exceeds the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_thread_i | input | 1 | 1 = two-thread fetch, 0 = single-thread fetch |
| wide_i | input | 1 | 1 = 16-instruction width, 0 = 8-instruction width |
| miss_blk_i | input | 8 | Per-thread instruction-cache miss block |
| q_nempty_i | input | 8 | Per-thread fetch target queue non-empty |
| occ_i | input | 56 | Per-thread in-flight front-end instruction count, 7 bits each |
| avail_i | input | 40 | Per-thread deliverable instruction count, 5 bits each |
| buf_free_i | input | 6 | Free entries in the fetch buffer |
| grant_o | output | 8 | Threads granted this cycle |
| prim_o | output | 8 | One-hot primary grant |
| alloc_o | output | 40 | Slots allocated per thread, 5 bits each |

## Verification
Several stimulus patterns are applied, and each one separates a different effect.

- Unequal occupancy counts show that the lowest count wins, rather than the lowest thread index.
- All-equal counts applied over consecutive cycles trace the pointer as it advances past the last granted thread, including after a second-thread grant and across the wrap.
- Miss-blocked threads, empty queues and zero-deliverable threads that would otherwise have won show that each exclusion rule works by itself.
- Deliverable counts below, equal to and above the width show the difference between the two modes and between a partial fill and a full one.
- A buffer-free value just below the width and one exactly equal to it mark the stall boundary.

// File: rtl/smt_fetch_pick.sv
module smt_fetch_pick #(
  parameter int NT     = 8,
  parameter int CNTW   = 7,
  parameter int SLOTW  = 5,
  parameter int FREEW  = 6,
  parameter int NARROW = 8,
  parameter int WIDE   = 16,
  localparam int PTRW  = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  two_thread_i,
  input  logic                  wide_i,
  input  logic [NT-1:0]         miss_blk_i,
  input  logic [NT-1:0]         q_nempty_i,
  input  logic [NT*CNTW-1:0]    occ_i,
  input  logic [NT*SLOTW-1:0]   avail_i,
  input  logic [FREEW-1:0]      buf_free_i,
  output logic [NT-1:0]         grant_o,
  output logic [NT-1:0]         prim_o,
  output logic [NT*SLOTW-1:0]   alloc_o
);

  function automatic logic [PTRW:0] pick(input logic [NT-1:0] m,
                                         input logic [NT*CNTW-1:0] occ,
                                         input logic [PTRW-1:0] p);
    logic            found;
    logic [PTRW-1:0] idx;
    logic [CNTW-1:0] best;
    int              t;
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NT; i++) begin
      t = int'(p) + i;
      if (t >= NT) t = t - NT;
      if (m[t] && (!found || occ[t*CNTW +: CNTW] < best)) begin
        found = 1'b1;
        idx   = PTRW'(t);
        best  = occ[t*CNTW +: CNTW];
      end
    end
    return {found, idx};
  endfunction

  logic [PTRW-1:0]    rr_q;
  logic [SLOTW-1:0]   width, av1, av2, s1, s2, rem;
  logic               stall, found1, found2, use2;
  logic [PTRW-1:0]    idx1, idx2, last;
  logic [NT-1:0]      elig, mask2, one1;
  logic [NT-1:0]      grant_n, prim_n;
  logic [NT*SLOTW-1:0] alloc_n;

  assign width = wide_i ? SLOTW'(WIDE) : SLOTW'(NARROW);
  assign stall = buf_free_i < FREEW'(width);

  always_comb begin
    for (int t = 0; t < NT; t++)
      elig[t] = ~miss_blk_i[t] & q_nempty_i[t] & (avail_i[t*SLOTW +: SLOTW] != '0) & ~stall;
  end

  assign {found1, idx1} = pick(elig, occ_i, rr_q);
  assign one1  = found1 ? (NT'(1) << idx1) : '0;
  assign mask2 = elig & ~one1 & {NT{two_thread_i}};
  assign {found2, idx2} = pick(mask2, occ_i, rr_q);

  assign av1  = avail_i[idx1*SLOTW +: SLOTW];
  assign av2  = avail_i[idx2*SLOTW +: SLOTW];
  assign s1   = (av1 < width) ? av1 : width;
  assign rem  = width - s1;
  assign use2 = found1 && found2 && (rem != '0);
  assign s2   = (av2 < rem) ? av2 : rem;
  assign last = use2 ? idx2 : idx1;

  always_comb begin
    grant_n = '0;
    prim_n  = '0;
    alloc_n = '0;
    if (found1) begin
      grant_n[idx1] = 1'b1;
      prim_n[idx1]  = 1'b1;
      alloc_n[idx1*SLOTW +: SLOTW] = s1;
    end
    if (use2) begin
      grant_n[idx2] = 1'b1;
      alloc_n[idx2*SLOTW +: SLOTW] = s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q    <= '0;
      grant_o <= '0;
      prim_o  <= '0;
      alloc_o <= '0;
    end else begin
      grant_o <= grant_n;
      prim_o  <= prim_n;
      alloc_o <= alloc_n;
      if (found1)
        rr_q <= (int'(last) == NT-1) ? '0 : last + 1'b1;
    end
  end

endmodule

// File: rtl/smt_fetch_pick_chk.sv
module smt_fetch_pick_chk #(
  parameter int NT     = 8,
  parameter int SLOTW  = 5,
  parameter int FREEW  = 6,
  parameter int NARROW = 8,
  parameter int WIDE   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                two_thread_i,
  input logic                wide_i,
  input logic [NT-1:0]       miss_blk_i,
  input logic [FREEW-1:0]    buf_free_i,
  input logic [NT-1:0]       grant_o,
  input logic [NT-1:0]       prim_o,
  input logic [NT*SLOTW-1:0] alloc_o
);

  int total;
  logic [NT-1:0] slot_nz;
  always_comb begin
    total = 0;
    for (int t = 0; t < NT; t++) begin
      total = total + int'(alloc_o[t*SLOTW +: SLOTW]);
      slot_nz[t] = alloc_o[t*SLOTW +: SLOTW] != '0;
    end
  end

  int width_now;
  assign width_now = wide_i ? WIDE : NARROW;

  assert_blocked_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_blk_i != '0) |=> ((grant_o & $past(miss_blk_i)) == '0));

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !two_thread_i |=> ($countones(grant_o) <= 1));

  assert_two_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) <= 2);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(buf_free_i) < width_now) |=> (grant_o == '0 && alloc_o == '0));

  assert_prim_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prim_o) && ((prim_o & ~grant_o) == '0));

  assert_slots_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_nz == grant_o);

  assert_slot_total_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (total <= $past(width_now)));

endmodule

bind smt_fetch_pick smt_fetch_pick_chk #(
  .NT(NT), .SLOTW(SLOTW), .FREEW(FREEW), .NARROW(NARROW), .WIDE(WIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .two_thread_i(two_thread_i), .wide_i(wide_i),
  .miss_blk_i(miss_blk_i), .buf_free_i(buf_free_i), .grant_o(grant_o),
  .prim_o(prim_o), .alloc_o(alloc_o)
);

// File: tb/tb_smt_fetch_pick.sv
module tb_smt_fetch_pick;
  localparam int NT = 8, CNTW = 7, SLOTW = 5, FREEW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic two_thread_i = 1'b0, wide_i = 1'b0;
  logic [NT-1:0] miss_blk_i = '0, q_nempty_i = '0;
  logic [NT*CNTW-1:0] occ_i = '0;
  logic [NT*SLOTW-1:0] avail_i = '0;
  logic [FREEW-1:0] buf_free_i = '0;
  logic [NT-1:0] grant_o, prim_o;
  logic [NT*SLOTW-1:0] alloc_o;

  int tests = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  smt_fetch_pick dut (.*);

  typedef struct packed {
    logic        mode;
    logic        wide;
    logic [7:0]  miss;
    logic [7:0]  nemp;
    logic [55:0] cnt;
    logic [4:0]  av;
    logic [5:0]  free;
    logic [7:0]  eg;
    logic [7:0]  ep;
    logic [4:0]  s1;
    logic [4:0]  s2;
  } vec_t;

  localparam logic [55:0] ALL4 = {8{7'd4}};

  // Consecutive vectors: the tie pointer carries from one row to the next.
  localparam vec_t VECS [10] = '{
    // R1 R6: t7 lowest, t1 next; 5 slots, then 3 of 8 left
    '{1'b1, 1'b0, 8'h00, 8'hFF, {7'd2,7'd9,7'd9,7'd9,7'd9,7'd9,7'd3,7'd5}, 5'd5, 6'd32, 8'h82, 8'h80, 5'd5, 5'd3},
    // R4 R7 R5: tie, pointer at 2, width 16
    '{1'b0, 1'b1, 8'h00, 8'hFF, ALL4, 5'd10, 6'd32, 8'h04, 8'h04, 5'd10, 5'd0},
    // R2: t3 miss-blocked, t4 wins; capped at 8
    '{1'b0, 1'b0, 8'h08, 8'hFF, ALL4, 5'd12, 6'd32, 8'h10, 8'h10, 5'd8, 5'd0},
    // R3 R6: t5 queue empty, t6 then t7
    '{1'b1, 1'b0, 8'h00, 8'hDF, ALL4, 5'd3, 6'd32, 8'hC0, 8'h40, 5'd3, 5'd3},
    // R8: 10 free below width 16
    '{1'b1, 1'b1, 8'h00, 8'hFF, ALL4, 5'd16, 6'd10, 8'h00, 8'h00, 5'd0, 5'd0},
    // R8 boundary: 8 free equals width 8; pointer wrapped to 0
    '{1'b0, 1'b0, 8'h00, 8'hFF, ALL4, 5'd8, 6'd8, 8'h01, 8'h01, 5'd8, 5'd0},
    // R6: primary fills width, no second
    '{1'b1, 1'b1, 8'h00, 8'hFF, ALL4, 5'd16, 6'd32, 8'h02, 8'h02, 5'd16, 5'd0},
    // R2: all blocked
    '{1'b1, 1'b1, 8'hFF, 8'hFF, ALL4, 5'd16, 6'd32, 8'h00, 8'h00, 5'd0, 5'd0},
    // R1 R4: t5 and t6 tie at 1, scan from 2 favours t5
    '{1'b1, 1'b1, 8'h00, 8'hFF, {7'd30,7'd1,7'd1,7'd30,7'd30,7'd30,7'd30,7'd30}, 5'd9, 6'd32, 8'h60, 8'h20, 5'd9, 5'd7},
    // R4: pointer past t6 lands on t7
    '{1'b0, 1'b0, 8'h00, 8'hFF, ALL4, 5'd8, 6'd32, 8'h80, 8'h80, 5'd8, 5'd0}
  };

  task automatic drive(input logic m, input logic w, input logic [7:0] mb,
                       input logic [7:0] ne, input logic [55:0] c,
                       input logic [39:0] a, input logic [5:0] f);
    two_thread_i = m; wide_i = w; miss_blk_i = mb; q_nempty_i = ne;
    occ_i = c; avail_i = a; buf_free_i = f;
  endtask

  task automatic check(input string req, input logic [7:0] eg, input logic [7:0] ep,
                       input logic [4:0] s1, input logic [4:0] s2);
    logic [4:0] exp_s;
    logic [7:0] sec;
    sec = eg & ~ep;
    tests++;
    if (grant_o !== eg || prim_o !== ep) begin
      fails++;
      $display("FAIL %s grant=%h prim=%h expected grant=%h prim=%h", req, grant_o, prim_o, eg, ep);
    end
    for (int t = 0; t < NT; t++) begin
      exp_s = ep[t] ? s1 : (sec[t] ? s2 : 5'd0);
      tests++;
      if (alloc_o[t*SLOTW +: SLOTW] !== exp_s) begin
        fails++;
        $display("FAIL %s slots thread %0d = %0d expected %0d", req, t, alloc_o[t*SLOTW +: SLOTW], exp_s);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset", 8'h00, 8'h00, 5'd0, 5'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      drive(VECS[i].mode, VECS[i].wide, VECS[i].miss, VECS[i].nemp, VECS[i].cnt,
            {8{VECS[i].av}}, VECS[i].free);
      @(negedge clk);
      check($sformatf("table row %0d", i), VECS[i].eg, VECS[i].ep, VECS[i].s1, VECS[i].s2);
    end
    // R3 R6: t1 lowest but zero avail; t0 gets 6, t2 fills 10. Pointer is now 0.
    drive(1'b1, 1'b1, 8'h00, 8'hFF,
          {7'd50,7'd50,7'd50,7'd50,7'd50,7'd2,7'd0,7'd1},
          {5'd16,5'd16,5'd16,5'd16,5'd16,5'd16,5'd0,5'd6}, 6'd32);
    @(negedge clk);
    check("R3 R6 zero-avail skip", 8'h05, 8'h01, 5'd6, 5'd10);
    // R6: only one eligible in two-thread mode
    drive(1'b1, 1'b0, 8'h00, 8'h08, ALL4, {8{5'd4}}, 6'd32);
    @(negedge clk);
    check("R6 lone thread", 8'h08, 8'h08, 5'd4, 5'd0);
    // R9: registered by one cycle; change inputs and look before the edge
    drive(1'b0, 1'b0, 8'h00, 8'h00, ALL4, {8{5'd4}}, 6'd32);
    #2;
    check("R9 hold before edge", 8'h08, 8'h08, 5'd4, 5'd0);
    @(negedge clk);
    check("R3 empty queues", 8'h00, 8'h00, 5'd0, 5'd0);
    // R4 R9: reset restores the pointer to 0
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset mid-run", 8'h00, 8'h00, 5'd0, 5'd0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 8'h00, 8'hFF, ALL4, {8{5'd8}}, 6'd32);
    @(negedge clk);
    check("R4 pointer reset", 8'h01, 8'h01, 5'd8, 5'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule